// File: doc/BRIEF.md
# Interrupt Expander With Set/Clear Masks

This block collects up to sixteen peripheral interrupt sources and presents them to a host processor as a single active-high, level-sensitive request line. Each source input passes through a two-flop synchronizer. A rising edge of the synchronized signal latches a pending bit in a status register. The host sees the output asserted for as long as any pending bit is also enabled.

Software uses a small 16-bit register port with a write strobe, a 2-bit address and a combinational read path. A status bit is cleared by writing a 1 to it. The enable mask is never written directly. One address sets enable bits and another clears them, and a 1 in either write touches only the bits it names. On the board, source 0 is a low-battery warning, source 1 is a push-button and source 2 is an overcurrent flag from a full-speed USB OTG port. The host services pending sources starting from bit 0.

Top module: `irq_expander`

## Requirements
- R1: After reset the status and the enable mask are all zeros, and `irq_o` is low.
- R2: A write to address 1 (mask set) sets every mask bit where `wdata_i` is 1 and leaves the other mask bits unchanged. A mask bit of 1 means the source is enabled.
- R3: A write to address 2 (mask clear) clears every mask bit where `wdata_i` is 1 and leaves the other mask bits unchanged.
- R4: Reading address 1 or address 2 returns the current mask. Reading address 3 returns zero.
- R5: A write to address 0 (status) clears every status bit where `wdata_i` is 1, and a 0 bit has no effect. Reading address 0 returns the raw status without masking.
- R6: A status bit is set by a rising edge of its source after the two-flop synchronizer, whether or not the source is enabled. The bit is set on the third rising clock edge after the input changes. A source held high does not set its bit again after that bit is cleared.
- R7: When a source edge and a clearing write to the same status bit happen on the same clock edge, the bit ends up set.
- R8: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero.
- R9: Writing 0xFFFF to the mask-clear address and then to the status address leaves every source disabled and none pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Asynchronous interrupt source lines, bit n is source n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask set, 2 mask clear |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level-high interrupt request to the host |

## Verification
A register write takes effect on the clock edge that samples it. The bench drives each write on a falling edge and reads back on the next falling edge, because the read path is combinational. A source change reaches the status register on the third rising edge, so the bench waits three rising edges and then samples on the falling edge. The set-versus-clear race is staged by placing the clearing write exactly on that third edge. `irq_o` is combinational from the registers, so the bench checks it in the same cycle as the status and mask reads.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS   = 2'd0,
    REG_MASK_SET = 2'd1,
    REG_MASK_CLR = 2'd2,
    REG_SPARE    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] prev_q, status_q, rise, clr_bits;

  assign rise     = sync_i & ~prev_q;
  assign clr_bits = clr_en_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      // set has priority over clear in the same cycle
      status_q <= (status_q & ~clr_bits) | rise;
    end
  end

  assign status_o = status_q;

  p_edge_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));
  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((status_q & $past(clr_data_i & ~rise)) == '0));
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && rise == '0) |=> $stable(status_q));
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (set_en_i) mask_q <= mask_q | wdata_i;
    else if (clr_en_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((mask_q & $past(wdata_i)) == '0));
  p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i || clr_en_i) |=> ((mask_q & ~$past(wdata_i)) == ($past(mask_q) & ~$past(wdata_i))));
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i || clr_en_i) |=> $stable(mask_q));
endmodule

// File: rtl/irq_reg_dec.sv
module irq_reg_dec
  import irq_exp_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  status_i,
  input  logic [WIDTH-1:0]  mask_i,
  output logic              we_status_o,
  output logic              we_set_o,
  output logic              we_clr_o,
  output logic [WIDTH-1:0]  rdata_o
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr_i);

  assign we_status_o = we_i && (sel == REG_STATUS);
  assign we_set_o    = we_i && (sel == REG_MASK_SET);
  assign we_clr_o    = we_i && (sel == REG_MASK_CLR);

  always_comb begin
    unique case (sel)
      REG_STATUS:   rdata_o = status_i;
      REG_MASK_SET,
      REG_MASK_CLR: rdata_o = mask_i;
      default:      rdata_o = '0;
    endcase
  end

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_status_o, we_set_o, we_clr_o}));
endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irq_exp_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_sync, status, mask;
  logic               we_status, we_set, we_clr;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(src_i), .sync_o(src_sync));

  irq_reg_dec #(.WIDTH(NUM_SRC)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .status_i(status), .mask_i(mask), .we_status_o(we_status),
    .we_set_o(we_set), .we_clr_o(we_clr), .rdata_o(rdata_o));

  irq_status #(.WIDTH(NUM_SRC)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(src_sync),
    .clr_en_i(we_status), .clr_data_i(wdata_i), .status_o(status));

  irq_mask #(.WIDTH(NUM_SRC)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_en_i(we_set), .clr_en_i(we_clr),
    .wdata_i(wdata_i), .mask_o(mask));

  assign irq_o = |(status & mask);

  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == '0 || mask == '0) |-> !irq_o);
endmodule

// File: tb/irq_expander_bench.sv
module irq_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_expander u_irq_expander (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [15:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] st_model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1 status", 16'h0000);
    rd(2'd1, "R1 mask",   16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    // R2 / R4
    wr(2'd1, 16'h00F0); rd(2'd1, "R2 set", 16'h00F0);
    wr(2'd1, 16'h0101); rd(2'd1, "R2 accumulate", 16'h01F1);
    rd(2'd2, "R4 clr readback", 16'h01F1);
    rd(2'd3, "R4 spare", 16'h0000);
    // R3
    wr(2'd2, 16'h0011); rd(2'd1, "R3 clear", 16'h01E0);
    wr(2'd2, 16'h0000); rd(2'd1, "R3 zero write", 16'h01E0);
    wr(2'd2, 16'hFFFF); rd(2'd1, "R3 clear all", 16'h0000);
    // R6 sweep: each source edge sets its own bit, mask off
    st_model = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); src = 16'(1) << i;
      settle();
      st_model |= 16'(1) << i;
      rd(2'd0, "R6 edge sets bit", st_model);
      chk("R8 masked irq", {15'd0, irq}, 16'h0000);
      @(negedge clk); src = '0;
      settle();
    end
    // R5 W1C
    wr(2'd0, 16'h00FF); rd(2'd0, "R5 w1c", 16'hFF00);
    wr(2'd0, 16'h0000); rd(2'd0, "R5 zero write", 16'hFF00);
    // R8 sweep: one enable at a time
    for (int i = 0; i < 16; i++) begin
      wr(2'd2, 16'hFFFF);
      wr(2'd1, 16'(1) << i);
      rd(2'd0, "R5 raw status", 16'hFF00);
      chk("R8 irq level", {15'd0, irq}, (i >= 8) ? 16'h0001 : 16'h0000);
    end
    // R9 init sequence
    wr(2'd2, 16'hFFFF); wr(2'd0, 16'hFFFF);
    rd(2'd1, "R9 mask", 16'h0000);
    rd(2'd0, "R9 status", 16'h0000);
    chk("R9 irq", {15'd0, irq}, 16'h0000);
    // R6 held level does not retrigger
    wr(2'd1, 16'h0001);
    @(negedge clk); src = 16'h0001;
    settle();
    chk("R8 enabled irq", {15'd0, irq}, 16'h0001);
    wr(2'd0, 16'h0001);
    repeat (4) @(negedge clk);
    rd(2'd0, "R6 no retrigger", 16'h0000);
    chk("R8 irq drops", {15'd0, irq}, 16'h0000);
    src = '0; settle();
    // R7 set wins over clear on the same edge
    src = 16'h0004;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 16'hFFFF;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(2'd0, "R7 set wins", 16'h0004);
    src = '0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule